// File: doc/BRIEF.md
# Vertical Blank Flag and NMI Controller

This block keeps the vertical-blank status bit seen by the CPU and drives the active-low non-maskable interrupt line. The frame timing logic sends it one-clock pulses at the start and the end of the blanking interval. The CPU side sends it a strobe for each status read and a write strobe, with a data bit, for the interrupt-enable control bit. Each status read registers the flag value onto `vbl_flag_rd`, which holds that value until the next read.

The block decides the single-clock races between these events. A read that lands one clock before the flag would rise returns clear, and the flag then stays clear for the whole interval. A read, or a disable of the interrupt, that lands within one clock of the rise keeps the interrupt from firing. The interrupt is asserted only when the flag and the enable have both been true for two clocks in a row. That two-clock window is what produces the race timing, and it also means an interrupt can fire again each time the enable is switched back on while the flag is still set.

All cycle figures below are for the default qualification length of two clocks. "Clock T" is the clock on which `vbl_start` is high.

Top module: `vblnmi_top`

## Requirements
- R1: After reset, `vbl_flag_rd` is 0, `nmi_n` is 1 and the interrupt enable is off. With the enable off, a blanking start never drives `nmi_n` low.
- R2: A status read on clock T, or on any later clock before another read or `vbl_end`, returns 1 on `vbl_flag_rd` from the following clock.
- R3: A status read clears the flag after returning its value. A second read later in the same interval returns 0.
- R4: A status read on clock T-1 returns 0. The flag then stays clear for that interval, so a later read returns 0 and `nmi_n` stays 1.
- R5: A status read on clock T-1, T or T+1 keeps `nmi_n` high for that interval. A read on T-4, T-3, T-2, T+2, T+3 or T+4 does not prevent the interrupt.
- R6: Writing enable=0 on any clock up to and including T+1 keeps `nmi_n` high for that interval. Writing it on T+2 or later does not prevent the interrupt. After any enable=0 write, `nmi_n` is 1 three clocks later.
- R7: With the enable on and no read, `nmi_n` first goes low on clock T+4. It stays low while the flag and the enable stay true.
- R8: Writing enable=1 on clock W while the flag is already set drives `nmi_n` low on clock W+4.
- R9: Writing enable=0 and then enable=1 while the flag is set produces a second falling edge on `nmi_n` in the same interval.
- R10: `vbl_end` clears the flag whatever else happens, so a following read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| vbl_start | input | 1 | One-clock pulse at the start of blanking |
| vbl_end | input | 1 | One-clock pulse at the end of blanking |
| status_rd | input | 1 | One-clock strobe for a CPU status read |
| ctrl_wr | input | 1 | One-clock strobe for a write of the enable bit |
| nmi_en_in | input | 1 | Enable value taken when `ctrl_wr` is high |
| vbl_flag_rd | output | 1 | Flag value returned by the last status read |
| nmi_n | output | 1 | Interrupt line, active low |

## Verification
The properties assume that `vbl_start` and `vbl_end` are single-clock pulses that never arrive on the same clock, and that reads are single-clock strobes. The same-clock read property also assumes that no read happened on the clock before it. The stimulus meets these assumptions by building every interval from one start pulse and one end pulse placed far apart. It puts at most one read and one enable write at each swept offset from -4 to +4 around the start. It always holds the inputs idle for a few clocks after reset and between intervals.

// File: rtl/vblnmi_pkg.sv
package vblnmi_pkg;
  // number of consecutive clocks flag AND enable must hold before the line drops
  localparam int unsigned QUAL_LEN_DEF = 2;

  typedef struct packed {
    logic start;
    logic stop;
    logic rd;
  } vbl_evt_t;
endpackage

// File: rtl/vblnmi_flag.sv
module vblnmi_flag
  import vblnmi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  vbl_evt_t evt,
  output logic     flag_q,
  output logic     rd_val_q
);
  logic arm_q;     // a read happened on the previous clock
  logic set_now;
  logic rd_val;
  logic flag_d;

  assign set_now = evt.start & ~arm_q;
  assign rd_val  = flag_q | set_now;

  always_comb begin
    flag_d = flag_q;
    if (evt.stop)     flag_d = 1'b0;
    else if (evt.rd)  flag_d = 1'b0;
    else if (set_now) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q    <= 1'b0;
      flag_q   <= 1'b0;
      rd_val_q <= 1'b0;
    end else begin
      arm_q  <= evt.rd;
      flag_q <= flag_d;
      if (evt.rd) rd_val_q <= rd_val;
    end
  end
endmodule

// File: rtl/vblnmi_enable.sv
module vblnmi_enable (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic din,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (rst)     en_q <= 1'b0;
    else if (wr) en_q <= din;
  end
endmodule

// File: rtl/vblnmi_qual.sv
module vblnmi_qual #(
  parameter int unsigned QUAL_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  input  logic en,
  output logic nmi_n
);
  localparam int unsigned HW = (QUAL_LEN < 2) ? 2 : QUAL_LEN;

  logic [HW-1:0] hist_q;
  logic          prod;

  assign prod = flag & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      nmi_n  <= 1'b1;
    end else begin
      hist_q <= {hist_q[HW-2:0], prod};
      nmi_n  <= ~(&hist_q);
    end
  end
endmodule

// File: rtl/vblnmi_top.sv
module vblnmi_top
  import vblnmi_pkg::*;
#(
  parameter int unsigned QUAL_LEN = QUAL_LEN_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic vbl_start,
  input  logic vbl_end,
  input  logic status_rd,
  input  logic ctrl_wr,
  input  logic nmi_en_in,
  output logic vbl_flag_rd,
  output logic nmi_n
);
  vbl_evt_t evt;
  logic     flag_q;
  logic     en_q;

  assign evt.start = vbl_start;
  assign evt.stop  = vbl_end;
  assign evt.rd    = status_rd;

  vblnmi_flag flag_i (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .flag_q   (flag_q),
    .rd_val_q (vbl_flag_rd)
  );

  vblnmi_enable en_i (
    .clk  (clk),
    .rst  (rst),
    .wr   (ctrl_wr),
    .din  (nmi_en_in),
    .en_q (en_q)
  );

  vblnmi_qual #(.QUAL_LEN(QUAL_LEN)) qual_i (
    .clk   (clk),
    .rst   (rst),
    .flag  (flag_q),
    .en    (en_q),
    .nmi_n (nmi_n)
  );
endmodule

// File: rtl/vblnmi_chk.sv
module vblnmi_chk (
  input logic clk,
  input logic rst,
  input logic vbl_start,
  input logic vbl_end,
  input logic status_rd,
  input logic ctrl_wr,
  input logic nmi_en_in,
  input logic vbl_flag_rd,
  input logic nmi_n,
  input logic flag_q,
  input logic en_q
);
  assert_rd_clears_R3: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> !flag_q);

  assert_end_clears_R10: assert property (@(posedge clk) disable iff (rst)
    vbl_end |=> !flag_q);

  assert_early_rd_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(status_rd) && vbl_start && !status_rd) |=> !flag_q);

  assert_same_clk_rd_R2: assert property (@(posedge clk) disable iff (rst)
    (status_rd && vbl_start && !$past(status_rd)) |=> vbl_flag_rd);

  assert_disable_quiets_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !nmi_en_in) |=> ##2 nmi_n);

  assert_nmi_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n) |-> ($past(flag_q && en_q, 2) && $past(flag_q && en_q, 3)));
endmodule

bind vblnmi_top vblnmi_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .vbl_start   (vbl_start),
  .vbl_end     (vbl_end),
  .status_rd   (status_rd),
  .ctrl_wr     (ctrl_wr),
  .nmi_en_in   (nmi_en_in),
  .vbl_flag_rd (vbl_flag_rd),
  .nmi_n       (nmi_n),
  .flag_q      (flag_q),
  .en_q        (en_q)
);

// File: tb/vblnmi_top_tb_top.sv
module vblnmi_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vbl_start = 1'b0, vbl_end = 1'b0, status_rd = 1'b0;
  logic ctrl_wr = 1'b0, nmi_en_in = 1'b0;
  logic vbl_flag_rd, nmi_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vblnmi_top dut_i (
    .clk(clk), .rst(rst), .vbl_start(vbl_start), .vbl_end(vbl_end),
    .status_rd(status_rd), .ctrl_wr(ctrl_wr), .nmi_en_in(nmi_en_in),
    .vbl_flag_rd(vbl_flag_rd), .nmi_n(nmi_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one clock of inputs; returns at the negedge after the posedge
  task automatic cyc(input bit vs, input bit ve, input bit rd, input bit wr, input bit en);
    vbl_start = vs; vbl_end = ve; status_rd = rd; ctrl_wr = wr; nmi_en_in = en;
    @(posedge clk);
    @(negedge clk);
    vbl_start = 0; vbl_end = 0; status_rd = 0; ctrl_wr = 0; nmi_en_in = 0;
  endtask

  task automatic frame(input bit hr, input int ro, input bit hc, input int co,
                       output int got, output int first, output int late);
    cyc(0, 0, 0, 1, 1);
    got = -1;
    first = -99;
    for (int c = -6; c <= 14; c++) begin
      cyc(c == 0, 0, hr && (c == ro), hc && (c == co), 0);
      if (hr && c == ro) got = int'(vbl_flag_rd);
      if (!nmi_n && first == -99) first = c + 1;
    end
    cyc(0, 0, 1, 0, 0);
    late = int'(vbl_flag_rd);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int got, first, late, falls;
    bit prev;
    @(negedge clk);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    check("R1 flag_rd after reset", int'(vbl_flag_rd), 0);
    check("R1 nmi_n after reset", int'(nmi_n), 1);
    // R1 enable off: no interrupt, flag still set
    first = -99;
    for (int c = 0; c <= 10; c++) begin
      cyc(c == 0, 0, 0, 0, 0);
      if (!nmi_n && first == -99) first = c + 1;
    end
    check("R1 no nmi with enable off", first, -99);
    cyc(0, 0, 1, 0, 0);
    check("R2 flag set reads 1", int'(vbl_flag_rd), 1);
    cyc(0, 0, 1, 0, 0);
    check("R3 second read 0", int'(vbl_flag_rd), 0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R2 R3 R4 R5 R7 sweep of read offset
    for (int ro = -4; ro <= 4; ro++) begin
      bit supf, supn;
      supf = (ro == -1);
      supn = (ro >= -1 && ro <= 1);
      frame(1, ro, 0, 0, got, first, late);
      check($sformatf("R2 R4 read value off=%0d", ro), got, (ro >= 0) ? 1 : 0);
      check($sformatf("R3 R4 later read off=%0d", ro), late, (supf || ro >= 0) ? 0 : 1);
      check($sformatf("R5 R7 nmi onset off=%0d", ro), first, supn ? -99 : 4);
    end

    // R6 sweep of disable offset
    for (int co = -4; co <= 4; co++) begin
      frame(0, 0, 1, co, got, first, late);
      check($sformatf("R6 nmi onset disable off=%0d", co), first, (co <= 1) ? -99 : 4);
      check($sformatf("R6 flag kept disable off=%0d", co), late, 1);
    end

    // R7 no read, no disable
    frame(0, 0, 0, 0, got, first, late);
    check("R7 onset T+4", first, 4);

    // R8 enable while flag set: write at 6, expect low at 10
    cyc(0, 0, 0, 1, 0);
    first = -99;
    for (int c = 0; c <= 16; c++) begin
      cyc(c == 0, 0, 0, c == 6, c == 6);
      if (!nmi_n && first == -99) first = c + 1;
    end
    check("R8 onset after late enable", first, 10);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    check("R10 nmi_n high after end", int'(nmi_n), 1);
    cyc(0, 0, 1, 0, 0);
    check("R10 read after end", int'(vbl_flag_rd), 0);

    // R9 toggle: off at 6, on at 8; falls at 4 and 12
    cyc(0, 0, 0, 1, 1);
    falls = 0;
    prev = nmi_n;
    first = -99;
    for (int c = 0; c <= 20; c++) begin
      cyc(c == 0, 0, 0, (c == 6) || (c == 8), c == 8);
      if (prev && !nmi_n) begin
        falls++;
        if (falls == 2) first = c + 1;
      end
      prev = nmi_n;
    end
    check("R9 falling edges", falls, 2);
    check("R9 second onset", first, 12);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    check("R10 end clears flag", int'(vbl_flag_rd), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule